// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame is kept, judging only by its 48-bit destination address. The address arrives one byte per clock, first byte flagged, and the block runs a byte-serial CRC-32 over the six bytes while it assembles the address. One cycle after the sixth byte it raises a result strobe together with two verdict bits. The match bit is the filter outcome. The accept bit is the final keep/drop decision.

Unicast addresses are compared against a small bank of exact-match entries. Multicast addresses can be checked against a hash table of 64, 128 or 256 bins, indexed from the CRC. Broadcast has its own rule. Several configuration inputs widen or override the filter: promiscuous, pass-all-multicast, hash-multicast, hash-or-exact, keep-all and broadcast-block. A plain word-write port loads the hash table and the exact-match entries.

Top module: `rx_dest_filter`

## Requirements
- R1: A byte with `rx_vld` and `rx_first` high starts an address. Each later byte with `rx_vld` high adds the next byte; cycles with `rx_vld` low are skipped. After the sixth byte is taken, `res_vld` is high for exactly one cycle, the next one. With no gaps, that is six cycles after the first byte. Bytes with `rx_first` low arriving while no address is open are ignored. A new `rx_first` byte abandons a partial address and starts again.
- R2: The first byte received occupies address bits [7:0], the second [15:8], and so on. Bit 0 (the LSB of the first byte) is the group bit. The address with all 48 bits set is broadcast.
- R3: The hash index is the top N bits of the bit-reversed complement of the reflected CRC-32. The CRC uses polynomial 0xEDB88320 and seed 0xFFFFFFFF, and runs over the six bytes in order, each byte LSB first. Bins 32w to 32w+31 sit in hash word w, with bin 32w+b at bit b.
- R4: N is the parameter HASH_LOG2. The values 6, 7 and 8 give 64, 128 and 256 bins. Any other value makes every hash lookup miss.
- R5: Write word 8+2k sets exact entry k bits [31:0]. Write word 9+2k sets bits [47:32] from data [15:0], with data bit 31 as the entry enable. Entry 0 (station) is enabled whatever its enable bit says. An enabled entry hits only if all 48 bits are equal and the entry is non-zero. Hash words are write words 0 to 7.
- R6: For a unicast address (group bit clear), match equals the exact-match hit.
- R7: For a multicast address that is not broadcast, the match bit depends on the configuration:
  - with pass-all-multicast set, match is 1;
  - otherwise, with hash-multicast set, match is the hash hit, or the exact hit when hash-or-exact is also set;
  - otherwise, match is the exact hit.
- R8: For broadcast, match is 1 unless `cfg_bcast_block` is set, in which case it is 0.
- R9: With `cfg_promisc` set, both match and accept are 1 for every address.
- R10: Accept equals match OR `cfg_recv_all`. Keep-all leaves the match bit unchanged.
- R11: Configuration and table state are read in the `res_vld` cycle itself.
- R12: After reset, `res_vld` is low and all table words and entries are zero, so no unicast address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_promisc | input | 1 | Promiscuous: accept and match everything |
| cfg_pass_mcast | input | 1 | Pass every multicast address |
| cfg_hash_mcast | input | 1 | Filter multicast through the hash table |
| cfg_hash_or_perfect | input | 1 | Multicast also passes on an exact hit |
| cfg_recv_all | input | 1 | Accept regardless of filter result |
| cfg_bcast_block | input | 1 | Reject broadcast |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table word address |
| wr_data | input | 32 | Table write data |
| rx_vld | input | 1 | Address byte valid |
| rx_first | input | 1 | Byte is the first address byte |
| rx_byte | input | 8 | Address byte |
| res_vld | output | 1 | Verdict strobe |
| res_accept | output | 1 | Keep the frame |
| res_match | output | 1 | Filter outcome |

## Verification
The bench builds three copies side by side with the same stimulus: HASH_LOG2 at 8 (the default), at 6, and at 5. The 8 and 6 builds place the same multicast address in different bins and different hash words, which exercises both the index width and the word selection. The build at 5 shows that an unsupported table size can never let a multicast through by hash while exact-match and broadcast rules still work.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned MAC_W       = 48;
  localparam int unsigned MAC_BYTES   = MAC_W / 8;
  localparam int unsigned HASH_REGION = 8;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;

  typedef struct packed {
    logic promisc;
    logic pass_mcast;
    logic hash_mcast;
    logic hash_or_perfect;
    logic recv_all;
    logic bcast_block;
  } filt_cfg_t;

  // one byte of the reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc32_byte(input logic [31:0] crc, input logic [7:0] data);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY_R;
      else                c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] bitrev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction
endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_first,
  input  logic [7:0]       byte_dat,
  output logic             cap_done,
  output logic [MAC_W-1:0] cap_addr,
  output logic [31:0]      cap_crc
);
  localparam int CNT_W = $clog2(MAC_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAC_BYTES - 1);

  logic [CNT_W-1:0] byte_idx_q;
  logic [CNT_W-1:0] slot;
  logic [31:0]      crc_run_q, crc_nxt;
  logic [MAC_W-1:0] addr_run_q, addr_ins;
  logic             take;

  always_comb begin
    slot     = byte_first ? '0 : byte_idx_q;
    crc_nxt  = crc32_byte(byte_first ? CRC_SEED : crc_run_q, byte_dat);
    addr_ins = byte_first ? '0 : addr_run_q;
    addr_ins[8*slot +: 8] = byte_dat;
    take     = byte_vld && (byte_first || byte_idx_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx_q <= '0;
      crc_run_q  <= CRC_SEED;
      addr_run_q <= '0;
      cap_done   <= 1'b0;
      cap_addr   <= '0;
      cap_crc    <= '0;
    end else begin
      cap_done <= 1'b0;
      if (take) begin
        if (!byte_first && byte_idx_q == LAST) begin
          cap_done   <= 1'b1;
          cap_addr   <= addr_ins;
          cap_crc    <= crc_nxt;
          byte_idx_q <= '0;
        end else begin
          byte_idx_q <= slot + CNT_W'(1);
          crc_run_q  <= crc_nxt;
          addr_run_q <= addr_ins;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_table.sv
module rxf_table
  import rxf_pkg::*;
#(
  parameter int NUM_PERFECT = 4,
  parameter int HASH_LOG2   = 8,
  parameter int ADDR_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [MAC_W-1:0]       lk_addr,
  input  logic [7:0]             hash_key,
  output logic                   hash_hit,
  output logic [NUM_PERFECT-1:0] perf_hit_vec
);
  localparam bit HASH_OK = (HASH_LOG2 >= 6) && (HASH_LOG2 <= 8);
  localparam int HWORDS  = HASH_OK ? (2 ** (HASH_LOG2 - 5)) : 1;

  logic unused_bits;
  assign unused_bits = ^{hash_key, wr_data[30:16]};

  generate
    if (HASH_OK) begin : g_hash
      localparam int WSEL_W = HASH_LOG2 - 5;
      logic [31:0]          hword_q [HWORDS];
      logic [HASH_LOG2-1:0] idx;
      logic [WSEL_W-1:0]    wsel;

      assign idx      = hash_key[7 -: HASH_LOG2];
      assign wsel     = idx[HASH_LOG2-1:5];
      assign hash_hit = hword_q[wsel][idx[4:0]];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int w = 0; w < HWORDS; w++) hword_q[w] <= '0;
        end else if (wr_en && wr_addr < ADDR_W'(HWORDS)) begin
          hword_q[wr_addr[WSEL_W-1:0]] <= wr_data;
        end
      end
    end else begin : g_nohash
      assign hash_hit = 1'b0;
    end
  endgenerate

  generate
    for (genvar k = 0; k < NUM_PERFECT; k++) begin : g_ent
      localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(HASH_REGION + 2*k);
      localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HASH_REGION + 2*k + 1);
      logic [MAC_W-1:0] ent_q;
      logic             ent_on;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q <= '0;
        end else if (wr_en && wr_addr == LO_A) begin
          ent_q[31:0] <= wr_data;
        end else if (wr_en && wr_addr == HI_A) begin
          ent_q[47:32] <= wr_data[15:0];
        end
      end

      if (k == 0) begin : g_station
        assign ent_on = 1'b1;
      end else begin : g_enable
        logic en_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                        en_q <= 1'b0;
          else if (wr_en && wr_addr == HI_A) en_q <= wr_data[31];
        end
        assign ent_on = en_q;
      end

      assign perf_hit_vec[k] = ent_on && (ent_q != '0) && (ent_q == lk_addr);
    end
  endgenerate
endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
  import rxf_pkg::*;
(
  input  filt_cfg_t        cfg,
  input  logic [MAC_W-1:0] addr,
  input  logic             hash_hit,
  input  logic             perf_hit,
  output logic             match,
  output logic             accept
);
  logic is_group, is_bcast;

  always_comb begin
    is_group = addr[0];
    is_bcast = &addr;
    if (cfg.promisc)          match = 1'b1;
    else if (is_bcast)        match = !cfg.bcast_block;
    else if (!is_group)       match = perf_hit;
    else if (cfg.pass_mcast)  match = 1'b1;
    else if (cfg.hash_mcast)  match = hash_hit || (cfg.hash_or_perfect && perf_hit);
    else                      match = perf_hit;
    accept = match || cfg.recv_all;
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int  NUM_PERFECT = 4,
  parameter int  HASH_LOG2   = 8,
  localparam int ADDR_W      = $clog2(HASH_REGION + 2*NUM_PERFECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_promisc,
  input  logic              cfg_pass_mcast,
  input  logic              cfg_hash_mcast,
  input  logic              cfg_hash_or_perfect,
  input  logic              cfg_recv_all,
  input  logic              cfg_bcast_block,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rx_vld,
  input  logic              rx_first,
  input  logic [7:0]        rx_byte,
  output logic              res_vld,
  output logic              res_accept,
  output logic              res_match
);
  filt_cfg_t              cfg;
  logic                   cap_done;
  logic [MAC_W-1:0]       cap_addr;
  logic [31:0]            cap_crc;
  logic [31:0]            hash_word;
  logic                   hash_hit;
  logic [NUM_PERFECT-1:0] perf_hit_vec;
  logic                   perf_hit;

  assign cfg = '{promisc: cfg_promisc, pass_mcast: cfg_pass_mcast,
                 hash_mcast: cfg_hash_mcast, hash_or_perfect: cfg_hash_or_perfect,
                 recv_all: cfg_recv_all, bcast_block: cfg_bcast_block};

  rxf_addr_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .byte_vld(rx_vld), .byte_first(rx_first), .byte_dat(rx_byte),
    .cap_done(cap_done), .cap_addr(cap_addr), .cap_crc(cap_crc)
  );

  assign hash_word = bitrev32(~cap_crc);

  rxf_table #(.NUM_PERFECT(NUM_PERFECT), .HASH_LOG2(HASH_LOG2), .ADDR_W(ADDR_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lk_addr(cap_addr), .hash_key(hash_word[31:24]),
    .hash_hit(hash_hit), .perf_hit_vec(perf_hit_vec)
  );

  logic unused_low;
  assign unused_low = ^hash_word[23:0];
  assign perf_hit   = |perf_hit_vec;

  rxf_verdict u_vd (
    .cfg(cfg), .addr(cap_addr), .hash_hit(hash_hit), .perf_hit(perf_hit),
    .match(res_match), .accept(res_accept)
  );

  assign res_vld = cap_done;
endmodule

module rx_dest_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_vld,
  input logic        rx_first,
  input logic        cfg_promisc,
  input logic        cfg_recv_all,
  input logic        cfg_bcast_block,
  input logic        res_vld,
  input logic        res_accept,
  input logic        res_match,
  input logic [47:0] cap_addr,
  input logic        perf_hit
);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);
  assert_restart_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_first) |=> !res_vld);
  assert_zero_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && cap_addr == 48'h0) |-> !perf_hit);
  assert_unicast_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !cap_addr[0] && !cfg_promisc) |-> (res_match == perf_hit));
  assert_bcast_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && &cap_addr && !cfg_bcast_block) |-> res_match);
  assert_bcast_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && &cap_addr && cfg_bcast_block && !cfg_promisc) |-> !res_match);
  assert_promisc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && cfg_promisc) |-> (res_accept && res_match));
  assert_keep_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && cfg_recv_all) |-> res_accept);
  assert_match_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_match) |-> res_accept);
endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_first(rx_first),
  .cfg_promisc(cfg_promisc), .cfg_recv_all(cfg_recv_all), .cfg_bcast_block(cfg_bcast_block),
  .res_vld(res_vld), .res_accept(res_accept), .res_match(res_match),
  .cap_addr(cap_addr), .perf_hit(perf_hit)
);

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_promisc = 0, cfg_pass_mcast = 0, cfg_hash_mcast = 0;
  logic cfg_hash_or_perfect = 0, cfg_recv_all = 0, cfg_bcast_block = 0;
  logic wr_en = 0; logic [3:0] wr_addr = 0; logic [31:0] wr_data = 0;
  logic rx_vld = 0, rx_first = 0; logic [7:0] rx_byte = 0;
  logic [2:0] o_vld, o_acc, o_mat;
  int n_of [3] = '{8, 6, 5};

  rx_dest_filter uut (.clk, .rst_n, .cfg_promisc, .cfg_pass_mcast, .cfg_hash_mcast,
    .cfg_hash_or_perfect, .cfg_recv_all, .cfg_bcast_block, .wr_en, .wr_addr, .wr_data,
    .rx_vld, .rx_first, .rx_byte, .res_vld(o_vld[0]), .res_accept(o_acc[0]), .res_match(o_mat[0]));
  rx_dest_filter #(.HASH_LOG2(6)) uut_h64 (.clk, .rst_n, .cfg_promisc, .cfg_pass_mcast, .cfg_hash_mcast,
    .cfg_hash_or_perfect, .cfg_recv_all, .cfg_bcast_block, .wr_en, .wr_addr, .wr_data,
    .rx_vld, .rx_first, .rx_byte, .res_vld(o_vld[1]), .res_accept(o_acc[1]), .res_match(o_mat[1]));
  rx_dest_filter #(.HASH_LOG2(5)) uut_nohash (.clk, .rst_n, .cfg_promisc, .cfg_pass_mcast, .cfg_hash_mcast,
    .cfg_hash_or_perfect, .cfg_recv_all, .cfg_bcast_block, .wr_en, .wr_addr, .wr_data,
    .rx_vld, .rx_first, .rx_byte, .res_vld(o_vld[2]), .res_accept(o_acc[2]), .res_match(o_mat[2]));

  int vectors = 0, errors = 0;
  string tag = "R12";
  logic [31:0] sh_hash [8];
  logic [47:0] sh_ent [4];
  logic        sh_en [4];
  logic        exp_vld = 0;
  logic [47:0] exp_addr = 0, abuf = 0;
  int          got = 0;

  // non-reflected MSB-first CRC on mirrored bits: equals bit-reversal of the reflected form
  function automatic logic [31:0] crc_norm(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = r[31] ^ a[i];
      r = r << 1;
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  function automatic int bin_of(input int n, input logic [47:0] a);
    logic [31:0] r;
    r = ~crc_norm(a);
    return int'(r >> (32 - n));
  endfunction

  function automatic void model(input int n, input logic [47:0] a, output logic acc, output logic mat);
    logic hit, perf;
    int idx;
    hit = 0; perf = 0;
    if (n >= 6 && n <= 8) begin idx = bin_of(n, a); hit = sh_hash[idx/32][idx%32]; end
    for (int k = 0; k < 4; k++)
      if ((k == 0 || sh_en[k]) && a != 48'h0 && sh_ent[k] == a) perf = 1;
    if (cfg_promisc) mat = 1;
    else if (a == {48{1'b1}}) mat = !cfg_bcast_block;
    else if (!a[0]) mat = perf;
    else if (cfg_pass_mcast) mat = 1;
    else if (cfg_hash_mcast) mat = hit | (cfg_hash_or_perfect & perf);
    else mat = perf;
    acc = mat | cfg_recv_all;
  endfunction

  task automatic check_all();
    for (int u = 0; u < 3; u++) begin
      logic ea, em;
      ea = 0; em = 0;
      if (exp_vld) model(n_of[u], exp_addr, ea, em);
      vectors++;
      if (o_vld[u] !== exp_vld || (exp_vld && (o_acc[u] !== ea || o_mat[u] !== em))) begin
        errors++;
        $display("FAIL %s N=%0d addr=%h: vld/acc/mat got %b%b%b expected %b%b%b", tag, n_of[u],
                 exp_addr, o_vld[u], o_acc[u], o_mat[u], exp_vld, ea, em);
      end
    end
  endtask

  task automatic cyc(input logic v, input logic f, input logic [7:0] b,
                     input logic we, input logic [3:0] wa, input logic [31:0] wd);
    @(negedge clk);
    check_all();
    rx_vld = v; rx_first = f; rx_byte = b; wr_en = we; wr_addr = wa; wr_data = wd;
    exp_vld = 0;
    if (we) begin
      if (wa < 8) sh_hash[wa] = wd;
      else if (wa[0] == 0) sh_ent[(wa-8)/2][31:0] = wd;
      else begin sh_ent[(wa-8)/2][47:32] = wd[15:0]; sh_en[(wa-8)/2] = wd[31]; end
    end
    if (v) begin
      if (f) begin got = 1; abuf = 0; abuf[7:0] = b; end
      else if (got > 0) begin
        abuf[8*got +: 8] = b; got++;
        if (got == 6) begin exp_vld = 1; exp_addr = abuf; got = 0; end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 4'h0, 32'h0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(0, 0, 8'h00, 1, a, d);
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int b = 0; b < 6; b++) begin
      cyc(1, b == 0, a[8*b +: 8], 0, 4'h0, 32'h0);
      if (b < 5) idle(gap);
    end
    idle(2);
  endtask

  task automatic set_entry(input int k, input logic [47:0] a, input logic en);
    wr(4'(8 + 2*k), a[31:0]);
    wr(4'(9 + 2*k), {en, 15'h0, a[47:32]});
  endtask

  localparam logic [47:0] STA = 48'h5A4B_3C2D_1E02;
  localparam logic [47:0] U1  = 48'h0000_7766_AA10;
  localparam logic [47:0] U2  = 48'h1234_5678_9A0C;
  localparam logic [47:0] M1  = 48'h0100_5E00_0001;
  localparam logic [47:0] M2  = 48'hCC11_2233_4457;
  localparam logic [47:0] BC  = {48{1'b1}};

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] hv [8];
    for (int i = 0; i < 8; i++) sh_hash[i] = 0;
    for (int i = 0; i < 4; i++) begin sh_ent[i] = 0; sh_en[i] = 0; end
    tag = "R12"; idle(3);
    rst_n = 1'b1;
    idle(2);
    send(STA, 0);                                 // R12: empty table, no match
    tag = "R5";
    set_entry(0, STA, 1'b0); set_entry(1, U1, 1'b1);
    set_entry(2, U2, 1'b0);  set_entry(3, 48'h0, 1'b1);
    tag = "R6"; send(STA, 0); send(U1, 0); send(U2, 0);
    tag = "R5"; send(48'h0, 0); send(STA ^ 48'h8000_0000_0000, 0);
    tag = "R2"; send({STA[7:0], STA[15:8], STA[23:16], STA[31:24], STA[39:32], STA[47:40]}, 0);
    tag = "R1"; send(U1, 2);
    cyc(1, 0, 8'h55, 0, 0, 0); cyc(1, 0, 8'h66, 0, 0, 0); idle(3);   // stray bytes ignored
    for (int b = 0; b < 3; b++) cyc(1, b == 0, U2[8*b +: 8], 0, 0, 0);
    send(STA, 0);                                 // restart mid-address
    for (int f = 0; f < 3; f++)
      for (int b = 0; b < 6; b++) cyc(1, b == 0, U1[8*b +: 8], 0, 0, 0);
    idle(2);
    tag = "R8"; send(BC, 0); cfg_bcast_block = 1; send(BC, 1); cfg_bcast_block = 0;
    tag = "R3";
    for (int w = 0; w < 8; w++) hv[w] = 0;
    hv[bin_of(8, M1)/32][bin_of(8, M1)%32] = 1'b1;
    hv[bin_of(6, M1)/32][bin_of(6, M1)%32] = 1'b1;
    for (int w = 0; w < 8; w++) wr(4'(w), hv[w]);
    cfg_hash_mcast = 1; send(M1, 0); send(M2, 0);
    tag = "R4"; send(M1, 1);
    tag = "R7"; set_entry(2, M2, 1'b1); send(M2, 0);
    cfg_hash_or_perfect = 1; send(M2, 0); send(M1, 0);
    cfg_hash_mcast = 0; cfg_hash_or_perfect = 0; send(M1, 0); send(M2, 0);
    cfg_pass_mcast = 1; send(M1, 0); send(48'h0000_0000_0003, 0); cfg_pass_mcast = 0;
    tag = "R9"; cfg_promisc = 1; send(U2 ^ 48'h1, 0); send(48'h0, 0); cfg_bcast_block = 1; send(BC, 0);
    cfg_promisc = 0; cfg_bcast_block = 0;
    tag = "R10"; cfg_recv_all = 1; send(48'h0000_0000_0A0A, 0); send(STA, 0); cfg_recv_all = 0;
    tag = "R11";
    for (int b = 0; b < 6; b++) cyc(1, b == 0, U1[8*b +: 8], 0, 0, 0);
    cfg_promisc = 1; idle(1); cfg_promisc = 0; idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule